// File: doc/BRIEF.md
# Core-Edge Interrupt Negotiator

This block sits at the edge of one core and claims interrupts for it. It watches the broadcast channel, where the interrupt service port announces, for each interrupt table, a 64-bit mask of the priority levels that now hold pending entries. It keeps only the broadcasts addressed to the table this core monitors. It finds the highest pending level and compares it with the priority the core is currently running at. When the pending level is higher, the block asks the service port for the top entry of that table.

The entry comes back some time later. By then the core's priority may have risen, so the block checks the entry again against the core's present priority. If the entry is still strictly higher, the block raises a one-cycle trigger for the pipeline's control transfer. Otherwise it hands the entry back to the service port, as it would for a refused request. The core keeps executing throughout; only this small machine is busy. Broadcasts that arrive during a negotiation are not lost: the newest one is held and looked at again once the machine is idle.

Top module: `irq_negotiator`

## Requirements
- R1: After reset, req_valid, xfer_valid and ret_valid are all low, and no request appears until a matching broadcast arrives.
- R2: A broadcast whose bc_table differs from my_table has no effect: no request follows it.
- R3: Bit i of bc_mask stands for priority level i, and a higher index means a higher priority. A matching broadcast, taken while idle, raises req_valid two cycles after the broadcast cycle if and only if the mask is nonzero and its highest set bit is strictly greater than core_prio.
- R4: req_valid stays high until the cycle in which req_ready is high, then drops. Only one request is outstanding at a time.
- R5: In the cycle a non-empty response arrives (rsp_valid high, rsp_empty low), rsp_prio is compared with core_prio of that same cycle. If rsp_prio is strictly greater, xfer_valid is high for exactly one cycle, the next cycle, with ent_prio and ent_vector equal to the response.
- R6: If rsp_prio is equal to or below that core_prio, ret_valid rises the next cycle carrying the response in ent_prio and ent_vector. It holds with stable values until ret_ready is high.
- R7: A response with rsp_empty high returns the block to idle without raising xfer_valid or ret_valid.
- R8: Matching broadcasts that arrive during a negotiation are latched, and a later one replaces an earlier one. Two cycles after the block is idle again, the latest mask is evaluated under R3.
- R9: At most one of req_valid, xfer_valid and ret_valid is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| my_table | input | TBL_W | Identifier of the table this core monitors |
| bc_valid | input | 1 | Broadcast present this cycle |
| bc_table | input | TBL_W | Table the broadcast refers to |
| bc_mask | input | LEVELS | Pending-level mask, bit i = level i |
| core_prio | input | PRIO_W | Priority the core is running at |
| req_valid | output | 1 | Request for the table's top entry |
| req_ready | input | 1 | Service port accepts the request |
| rsp_valid | input | 1 | Response from the service port |
| rsp_empty | input | 1 | Response carries no entry |
| rsp_prio | input | PRIO_W | Priority of the returned entry |
| rsp_vector | input | VEC_W | Payload of the returned entry |
| xfer_valid | output | 1 | One-cycle control-transfer trigger |
| ret_valid | output | 1 | Entry handed back to the service port |
| ret_ready | input | 1 | Service port takes back the entry |
| ent_prio | output | PRIO_W | Priority of the entry being taken or returned |
| ent_vector | output | VEC_W | Payload of the entry being taken or returned |

## Verification
A matching broadcast is captured at one edge and evaluated at the next, so the bench checks req_valid at the second falling edge after it drives the broadcast. A response is decided at the edge where it is sampled, so xfer_valid or ret_valid is checked at the very next falling edge. xfer_valid is checked low again one cycle later. A latched broadcast needs one edge to return to idle and one more to raise a request, and the bench samples there. All inputs change just after a falling edge and all outputs are read at falling edges, so every check falls halfway between the edges that set up and change its value.

// File: rtl/irqn_pkg.sv
package irqn_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT,
        ST_XFER,
        ST_RET
    } neg_state_e;
endpackage

// File: rtl/irqn_prio_enc.sv
module irqn_prio_enc #(
    parameter int LEVELS = 64,
    localparam int IDX_W = $clog2(LEVELS)
) (
    input  logic [LEVELS-1:0] mask,
    output logic              vld,
    output logic [IDX_W-1:0]  idx
);
    // upper index wins: the last set bit seen in the ascending scan is kept
    always_comb begin
        vld = 1'b0;
        idx = '0;
        for (int i = 0; i < LEVELS; i++) begin
            if (mask[i]) begin
                vld = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/irqn_bcast_snoop.sv
module irqn_bcast_snoop #(
    parameter int LEVELS = 64,
    parameter int TBL_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TBL_W-1:0]  my_table,
    input  logic              bc_valid,
    input  logic [TBL_W-1:0]  bc_table,
    input  logic [LEVELS-1:0] bc_mask,
    input  logic              consume,
    output logic [LEVELS-1:0] mask_q,
    output logic              pend_q
);
    logic [LEVELS-1:0] mask_d;
    logic              pend_d;
    logic              hit;

    assign hit = bc_valid && (bc_table == my_table);

    always_comb begin
        mask_d = mask_q;
        pend_d = pend_q;
        if (hit) begin
            mask_d = bc_mask;
            pend_d = 1'b1;
        end else if (consume) begin
            pend_d = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            pend_q <= 1'b0;
        end else begin
            mask_q <= mask_d;
            pend_q <= pend_d;
        end
    end

    // R8
    latest_bcast_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (pend_q && mask_q == $past(bc_mask)));
endmodule

// File: rtl/irq_negotiator.sv
module irq_negotiator
    import irqn_pkg::*;
#(
    parameter int LEVELS = 64,
    parameter int TBL_W  = 4,
    parameter int VEC_W  = 12,
    localparam int PRIO_W = $clog2(LEVELS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TBL_W-1:0]  my_table,
    input  logic              bc_valid,
    input  logic [TBL_W-1:0]  bc_table,
    input  logic [LEVELS-1:0] bc_mask,
    input  logic [PRIO_W-1:0] core_prio,
    output logic              req_valid,
    input  logic              req_ready,
    input  logic              rsp_valid,
    input  logic              rsp_empty,
    input  logic [PRIO_W-1:0] rsp_prio,
    input  logic [VEC_W-1:0]  rsp_vector,
    output logic              xfer_valid,
    output logic              ret_valid,
    input  logic              ret_ready,
    output logic [PRIO_W-1:0] ent_prio,
    output logic [VEC_W-1:0]  ent_vector
);
    typedef struct packed {
        neg_state_e        st;
        logic [PRIO_W-1:0] prio;
        logic [VEC_W-1:0]  vec;
    } neg_regs_t;

    neg_regs_t         r_d, r_q;
    logic [LEVELS-1:0] held_mask;
    logic              held_pend;
    logic              consume;
    logic              top_vld;
    logic [PRIO_W-1:0] top_lvl;

    irqn_bcast_snoop #(.LEVELS(LEVELS), .TBL_W(TBL_W)) u_snoop (
        .clk      (clk),
        .rst_n    (rst_n),
        .my_table (my_table),
        .bc_valid (bc_valid),
        .bc_table (bc_table),
        .bc_mask  (bc_mask),
        .consume  (consume),
        .mask_q   (held_mask),
        .pend_q   (held_pend)
    );

    irqn_prio_enc #(.LEVELS(LEVELS)) u_enc (
        .mask (held_mask),
        .vld  (top_vld),
        .idx  (top_lvl)
    );

    always_comb begin
        r_d     = r_q;
        consume = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (held_pend) begin
                    consume = 1'b1;
                    if (top_vld && (top_lvl > core_prio)) r_d.st = ST_REQ;
                end
            end
            ST_REQ: begin
                if (req_ready) r_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (rsp_valid) begin
                    if (rsp_empty) begin
                        r_d.st = ST_IDLE;
                    end else begin
                        r_d.prio = rsp_prio;
                        r_d.vec  = rsp_vector;
                        r_d.st   = (rsp_prio > core_prio) ? ST_XFER : ST_RET;
                    end
                end
            end
            ST_XFER: r_d.st = ST_IDLE;
            ST_RET: begin
                if (ret_ready) r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '{st: ST_IDLE, default: '0};
        else        r_q <= r_d;
    end

    assign req_valid  = (r_q.st == ST_REQ);
    assign xfer_valid = (r_q.st == ST_XFER);
    assign ret_valid  = (r_q.st == ST_RET);
    assign ent_prio   = r_q.prio;
    assign ent_vector = r_q.vec;

    // R9
    single_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({req_valid, xfer_valid, ret_valid}));

    // R4
    req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> req_valid);

    // R5
    xfer_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid |=> !xfer_valid);

    // R5
    xfer_above_core_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid |-> (ent_prio > $past(core_prio)));

    // R6
    ret_not_above_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ret_valid) |-> (ent_prio <= $past(core_prio)));

    // R6
    ret_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && !ret_ready) |=> (ret_valid && $stable(ent_prio) && $stable(ent_vector)));
endmodule

// File: tb/irq_negotiator_test.sv
module irq_negotiator_test;
    localparam int LEVELS = 64;
    localparam int TBL_W  = 4;
    localparam int VEC_W  = 12;
    localparam int PRIO_W = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [TBL_W-1:0]  my_table = 4'd5;
    logic              bc_valid = 1'b0;
    logic [TBL_W-1:0]  bc_table = '0;
    logic [LEVELS-1:0] bc_mask = '0;
    logic [PRIO_W-1:0] core_prio = '0;
    logic              req_valid, xfer_valid, ret_valid;
    logic              req_ready = 1'b0;
    logic              rsp_valid = 1'b0;
    logic              rsp_empty = 1'b0;
    logic [PRIO_W-1:0] rsp_prio = '0;
    logic [VEC_W-1:0]  rsp_vector = '0;
    logic              ret_ready = 1'b0;
    logic [PRIO_W-1:0] ent_prio;
    logic [VEC_W-1:0]  ent_vector;

    int total = 0;
    int fails = 0;

    always #5 clk = ~clk;

    irq_negotiator #(.LEVELS(LEVELS), .TBL_W(TBL_W), .VEC_W(VEC_W)) uut (
        .clk(clk), .rst_n(rst_n), .my_table(my_table),
        .bc_valid(bc_valid), .bc_table(bc_table), .bc_mask(bc_mask),
        .core_prio(core_prio), .req_valid(req_valid), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_empty(rsp_empty), .rsp_prio(rsp_prio),
        .rsp_vector(rsp_vector), .xfer_valid(xfer_valid), .ret_valid(ret_valid),
        .ret_ready(ret_ready), .ent_prio(ent_prio), .ent_vector(ent_vector)
    );

    function automatic int top_of(input logic [LEVELS-1:0] m);
        int t = -1;
        for (int i = 0; i < LEVELS; i++) if (m[i]) t = i;
        return t;
    endfunction

    function automatic bit want_req(input logic [LEVELS-1:0] m, input int core);
        return top_of(m) > core;
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // drives one broadcast cycle; returns just after the capturing edge
    task automatic send_bc(input logic [TBL_W-1:0] t, input logic [LEVELS-1:0] m);
        bc_valid = 1'b1;
        bc_table = t;
        bc_mask  = m;
        @(negedge clk);
        bc_valid = 1'b0;
    endtask

    // called with the block in REQ; finishes with the block idle
    task automatic negotiate(input int rdelay, input bit empty, input logic [PRIO_W-1:0] p,
                             input logic [VEC_W-1:0] v, input logic [PRIO_W-1:0] newcore);
        for (int k = 0; k < rdelay; k++) begin
            @(negedge clk);
            chk(req_valid == 1'b1, "R4 request held", req_valid, 1);
        end
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
        chk(req_valid == 1'b0, "R4 request dropped after accept", req_valid, 0);
        core_prio  = newcore;
        rsp_valid  = 1'b1;
        rsp_empty  = empty;
        rsp_prio   = p;
        rsp_vector = v;
        @(negedge clk);
        rsp_valid = 1'b0;
        rsp_empty = 1'b0;
        if (empty) begin
            chk(!xfer_valid && !ret_valid, "R7 empty response", {xfer_valid, ret_valid}, 0);
        end else if (p > newcore) begin
            chk(xfer_valid && !ret_valid, "R5 transfer raised", {xfer_valid, ret_valid}, 2);
            chk(ent_prio == p && ent_vector == v, "R5 transfer entry",
                {ent_prio, ent_vector}, {p, v});
            @(negedge clk);
            chk(!xfer_valid, "R5 transfer pulse one cycle", xfer_valid, 0);
        end else begin
            chk(ret_valid && !xfer_valid, "R6 entry returned", {xfer_valid, ret_valid}, 1);
            for (int k = 0; k < (v % 3); k++) begin
                @(negedge clk);
                chk(ret_valid && ent_prio == p && ent_vector == v, "R6 return held",
                    {ret_valid, ent_prio, ent_vector}, {1'b1, p, v});
            end
            ret_ready = 1'b1;
            @(negedge clk);
            ret_ready = 1'b0;
        end
        chk(!req_valid && !xfer_valid && !ret_valid, "R9 idle after negotiation",
            {req_valid, xfer_valid, ret_valid}, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        total++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [LEVELS-1:0] m;
        logic [TBL_W-1:0]  t;
        bit                exp_req;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk(!req_valid && !xfer_valid && !ret_valid, "R1 reset outputs",
            {req_valid, xfer_valid, ret_valid}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!req_valid, "R1 no request without broadcast", req_valid, 0);

        // directed: other table ignored
        core_prio = 6'd0;
        send_bc(4'd3, 64'hFFFF_FFFF_FFFF_FFFF);
        @(negedge clk);
        chk(!req_valid, "R2 other table ignored", req_valid, 0);
        @(negedge clk);
        chk(!req_valid, "R2 other table still ignored", req_valid, 0);

        // directed: top level equal to core priority -> no request
        core_prio = 6'd20;
        send_bc(my_table, 64'h0000_0000_0010_0001);
        @(negedge clk);
        chk(!req_valid, "R3 equal level no request", req_valid, 0);

        // directed: bit 63 beats core 62, then core rises to 63 before response
        core_prio = 6'd62;
        send_bc(my_table, 64'h8000_0000_0000_0000);
        @(negedge clk);
        chk(req_valid, "R3 top bit requested", req_valid, 1);
        negotiate(2, 1'b0, 6'd63, 12'h0A5, 6'd63);

        // directed: latest broadcast during negotiation wins (high one)
        core_prio = 6'd10;
        send_bc(my_table, 64'd1 << 40);
        @(negedge clk);
        chk(req_valid, "R3 level 40 over core 10", req_valid, 1);
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
        send_bc(my_table, 64'd1 << 5);
        send_bc(my_table, 64'd1 << 50);
        rsp_valid = 1'b1; rsp_prio = 6'd40; rsp_vector = 12'h123;
        @(negedge clk);
        rsp_valid = 1'b0;
        chk(xfer_valid && ent_vector == 12'h123, "R5 transfer with pending broadcast",
            {xfer_valid, ent_vector}, {1'b1, 12'h123});
        @(negedge clk);
        chk(!req_valid, "R8 idle cycle first", req_valid, 0);
        @(negedge clk);
        chk(req_valid, "R8 latest broadcast requested", req_valid, 1);
        negotiate(0, 1'b1, 6'd0, 12'h0, 6'd10);

        // directed: latest broadcast during negotiation is low -> no request
        send_bc(my_table, 64'd1 << 30);
        @(negedge clk);
        chk(req_valid, "R3 level 30 requested", req_valid, 1);
        send_bc(my_table, 64'd1 << 60);
        send_bc(my_table, 64'd1 << 2);
        chk(req_valid, "R4 request held while broadcasts arrive", req_valid, 1);
        negotiate(0, 1'b0, 6'd9, 12'h777, 6'd10);
        repeat (2) @(negedge clk);
        chk(!req_valid, "R8 low latest mask no request", req_valid, 0);

        // random trials
        for (int n = 0; n < 400; n++) begin
            t = ($urandom % 4 == 0) ? TBL_W'($urandom) : my_table;
            case ($urandom % 4)
                0: m = '0;
                1: m = 64'd1 << ($urandom % 64);
                default: m = {$urandom, $urandom};
            endcase
            core_prio = PRIO_W'($urandom);
            exp_req = (t == my_table) && want_req(m, int'(core_prio));
            send_bc(t, m);
            @(negedge clk);
            chk(req_valid == exp_req, (t == my_table) ? "R3 random request" : "R2 random table",
                req_valid, exp_req);
            if (req_valid) begin
                negotiate($urandom % 3, ($urandom % 10) == 0, PRIO_W'($urandom),
                          VEC_W'($urandom), PRIO_W'($urandom));
            end
        end

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule